// File: doc/BRIEF.md
# Dual-Channel Transmit FIFO Frontend

This block is the transmit half of a programmed-I/O Ethernet MAC. Software loads frame bytes into one of two independent byte queues through a single 32-bit data register. A channel-select register decides which queue a data write lands in. Each write adds four bytes, least significant byte first. Each channel has its own length register. Writing a start command to a channel's go register sends that channel's bytes on a byte-wide stream output. The stream uses a valid/ready handshake and marks the first and last bytes.

When a frame completes, the channel's queue and its length are emptied, and the channel's bit in the interrupt status register is set. The interrupt line is high whenever a status bit and its matching enable bit are both set. Software clears status bits by writing ones to them. Writing bit 0 of the control register resets the whole block; that bit is never stored. Reads are combinational on the same address bus as writes. Queue depth is a parameter, 4096 bytes per channel by default.

Top module: `txfe_top`

## Requirements
- R1: A write to the data register (byte offset 0x08) appends four bytes to the queue picked by channel select, in the order wdata[7:0], [15:8], [23:16], [31:24]. Frames carry bytes in that order, and the other channel's queue is untouched.
- R2: A data write is dropped whole when the selected queue has fewer than 4 free bytes. Occupancy never exceeds the depth.
- R3: A write to channel select (offset 0x04) stores the value when it is below 2 and stores 0 otherwise. Reading offset 0x04 returns the stored value.
- R4: A write to a length register (channel 0 at 0x0C, channel 1 at 0x10) larger than the queue depth stores the depth; any other value is stored as written. The register reads back at the same offset.
- R5: A write to a go register (channel 0 at 0x14, channel 1 at 0x18) starts a frame only when wdata bit 0 is 1 and the transmit-enable bit (control bit 1, offset 0x00) is set. In every other case the write has no effect.
- R6: The frame carries exactly min(length register, bytes held) bytes. When that count is 0, no byte is sent and no status bit changes.
- R7: Frame bytes appear with tx_valid and move on only in cycles where tx_ready is also high. tx_sof marks the first byte and tx_eof marks the last. While a byte is stalled, tx_data and the markers hold steady.
- R8: After the last byte of a frame is accepted, that channel's queue is emptied, its length register reads 0, and its status bit is set (bit 0 for channel 0, bit 1 for channel 1).
- R9: Interrupt status is at offset 0x20 and interrupt enable is at offset 0x1C. irq equals the OR of (status AND enable). Writing 1s to status clears those bits, except that a completion in the same cycle keeps its own bit set.
- R10: Writing control with bit 0 set returns every register, queue and any frame in flight to the reset state, and then takes bit 1 as the new transmit enable. Control reads back {bit1 = enable, bit0 = 0}. Reset state: all registers read 0 and tx_valid is low.
- R11: A go write is ignored while a frame is still streaming; no second frame follows from it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Register byte offset for reads and writes |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| tx_data | output | 8 | Frame byte |
| tx_valid | output | 1 | Frame byte is valid |
| tx_sof | output | 1 | First byte of frame |
| tx_eof | output | 1 | Last byte of frame |
| tx_ready | input | 1 | Downstream accepts the byte |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check four things on every cycle:
- Queue occupancy stays within depth, and a data write to a full queue leaves occupancy unchanged.
- A stalled byte and its markers stay steady.
- A frame in flight is not replaced by another channel's frame before its last byte.
- Every completion sets its status bit and zeroes its length, and nothing starts while transmit is disabled.

Only the bench's scenarios can show byte ordering against the pushed words, the exact frame length taken from the length register or the held bytes, clamping of length and channel select, and that a queue really is empty after its frame. They also cover set-over-clear priority in the status register and a soft reset that cuts a frame short.

// File: rtl/txfe_pkg.sv
package txfe_pkg;
    localparam int NUM_CH = 2;

    localparam logic [7:0] OFF_CTRL  = 8'h00;
    localparam logic [7:0] OFF_CHSEL = 8'h04;
    localparam logic [7:0] OFF_DATA  = 8'h08;
    localparam logic [7:0] OFF_LEN0  = 8'h0C;
    localparam logic [7:0] OFF_GO0   = 8'h14;
    localparam logic [7:0] OFF_IEN   = 8'h1C;
    localparam logic [7:0] OFF_IST   = 8'h20;

    localparam int CTRL_RST_BIT = 0;
    localparam int CTRL_EN_BIT  = 1;

    function automatic logic [7:0] off_len(input int ch);
        return OFF_LEN0 + 8'(4 * ch);
    endfunction

    function automatic logic [7:0] off_go(input int ch);
        return OFF_GO0 + 8'(4 * ch);
    endfunction
endpackage

// File: rtl/txfe_fifo.sv
module txfe_fifo #(
    parameter int DEPTH_BYTES = 4096,
    localparam int PW = $clog2(DEPTH_BYTES) + 1,
    localparam int WORDS = DEPTH_BYTES / 4,
    localparam int WAW = PW - 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          push,
    input  logic [31:0]   push_word,
    input  logic          pop,
    output logic [7:0]    rd_byte,
    output logic [PW-1:0] used
);
    localparam logic [PW-1:0] DEPTH_L = PW'(DEPTH_BYTES);

    typedef struct packed {
        logic [PW-1:0] wp;
        logic [PW-1:0] rp;
    } ptr_t;

    ptr_t q, d;
    logic [31:0]    mem [WORDS];
    logic           room_ok;
    logic           push_eff;
    logic [WAW-1:0] waddr;

    always_comb begin
        used     = q.wp - q.rp;
        room_ok  = (DEPTH_L - used) >= PW'(4);
        push_eff = push && (clr || room_ok);
        waddr    = clr ? '0 : q.wp[PW-2:2];
        d = q;
        if (clr) begin
            d = '0;
        end
        if (push_eff) begin
            d.wp = (clr ? '0 : q.wp) + PW'(4);
        end
        if (pop && !clr) begin
            d.rp = q.rp + PW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_ff @(posedge clk) begin
        if (push_eff) mem[waddr] <= push_word;
    end

    assign rd_byte = mem[q.rp[PW-2:2]][{q.rp[1:0], 3'b000} +: 8];

    // Occupancy bound and drop-on-full behaviour
    p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        used <= DEPTH_L);
    p_full_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        push && !clr && !pop && !room_ok |=> used == $past(used));
endmodule

// File: rtl/txfe_stream.sv
module txfe_stream #(
    parameter int LW = 13,
    parameter int CW = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          start,
    input  logic [CW-1:0] start_chan,
    input  logic [LW-1:0] start_len,
    input  logic          tx_ready,
    output logic          busy,
    output logic [CW-1:0] chan,
    output logic          tx_valid,
    output logic          tx_sof,
    output logic          tx_eof,
    output logic          pop,
    output logic          done
);
    typedef struct packed {
        logic          busy;
        logic [CW-1:0] chan;
        logic          first;
        logic [LW-1:0] rem;
    } st_t;

    st_t q, d;
    logic fire;
    logic last;

    always_comb begin
        fire = q.busy && tx_ready;
        last = q.rem == LW'(1);
        d = q;
        if (flush) begin
            d = '0;
        end else begin
            if (fire) begin
                d.first = 1'b0;
                d.rem   = q.rem - LW'(1);
                if (last) d.busy = 1'b0;
            end
            if (start && !q.busy) begin
                d.busy  = 1'b1;
                d.chan  = start_chan;
                d.first = 1'b1;
                d.rem   = start_len;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy     = q.busy;
    assign chan     = q.chan;
    assign tx_valid = q.busy;
    assign tx_sof   = q.busy && q.first;
    assign tx_eof   = q.busy && last;
    assign pop      = fire && !flush;
    assign done     = fire && last && !flush;

    // A start never arrives with an empty frame
    p_start_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> start_len != '0);
    // Markers held while stalled
    p_mark_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && !tx_ready && !flush |=> tx_valid && $stable(tx_sof) && $stable(tx_eof));
endmodule

// File: rtl/txfe_top.sv
module txfe_top #(
    parameter int DEPTH_BYTES = 4096
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [7:0]  addr,
    input  logic [31:0] wdata,
    output logic [31:0] rdata,
    output logic [7:0]  tx_data,
    output logic        tx_valid,
    output logic        tx_sof,
    output logic        tx_eof,
    input  logic        tx_ready,
    output logic        irq
);
    import txfe_pkg::*;

    localparam int NCH = NUM_CH;
    localparam int CW  = $clog2(NCH);
    localparam int LW  = $clog2(DEPTH_BYTES) + 1;
    localparam logic [LW-1:0] DEPTH_L = LW'(DEPTH_BYTES);

    typedef struct packed {
        logic                     tx_en;
        logic [CW-1:0]            chsel;
        logic [NCH-1:0][LW-1:0]   len;
        logic [NCH-1:0]           ien;
        logic [NCH-1:0]           ist;
    } regs_t;

    regs_t q, d;

    logic                   srst;
    logic [NCH-1:0]         fifo_clr;
    logic [NCH-1:0]         fifo_push;
    logic [NCH-1:0]         fifo_pop;
    logic [NCH-1:0][7:0]    fifo_byte;
    logic [NCH-1:0][LW-1:0] fifo_used;
    logic [NCH-1:0][LW-1:0] eff_len;
    logic [NCH-1:0]         ist_set;

    logic          st_start;
    logic [CW-1:0] st_start_chan;
    logic [LW-1:0] st_start_len;
    logic          st_busy;
    logic [CW-1:0] st_chan;
    logic          st_pop;
    logic          st_done;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        txfe_fifo #(.DEPTH_BYTES(DEPTH_BYTES)) u_fifo (
            .clk       (clk),
            .rst_n     (rst_n),
            .clr       (fifo_clr[c]),
            .push      (fifo_push[c]),
            .push_word (wdata),
            .pop       (fifo_pop[c]),
            .rd_byte   (fifo_byte[c]),
            .used      (fifo_used[c])
        );
    end

    txfe_stream #(.LW(LW), .CW(CW)) u_stream (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (srst),
        .start      (st_start),
        .start_chan (st_start_chan),
        .start_len  (st_start_len),
        .tx_ready   (tx_ready),
        .busy       (st_busy),
        .chan       (st_chan),
        .tx_valid   (tx_valid),
        .tx_sof     (tx_sof),
        .tx_eof     (tx_eof),
        .pop        (st_pop),
        .done       (st_done)
    );

    always_comb begin
        srst          = wr_en && (addr == OFF_CTRL) && wdata[CTRL_RST_BIT];
        st_start      = 1'b0;
        st_start_chan = '0;
        st_start_len  = '0;
        d = q;

        if (wr_en && addr == OFF_CTRL) d.tx_en = wdata[CTRL_EN_BIT];
        if (wr_en && addr == OFF_CHSEL) d.chsel = (wdata < 32'(NCH)) ? wdata[CW-1:0] : '0;
        if (wr_en && addr == OFF_IEN) d.ien = wdata[NCH-1:0];

        for (int c = 0; c < NCH; c++) begin
            eff_len[c]   = (q.len[c] < fifo_used[c]) ? q.len[c] : fifo_used[c];
            ist_set[c]   = st_done && (st_chan == CW'(c));
            fifo_push[c] = wr_en && (addr == OFF_DATA) && (q.chsel == CW'(c));
            fifo_pop[c]  = st_pop && (st_chan == CW'(c));
            fifo_clr[c]  = srst || ist_set[c];
            if (wr_en && addr == off_len(c)) begin
                d.len[c] = (wdata > 32'(DEPTH_BYTES)) ? DEPTH_L : wdata[LW-1:0];
            end
            if (wr_en && addr == off_go(c) && wdata[0] && q.tx_en && !st_busy
                && !srst && eff_len[c] != '0) begin
                st_start      = 1'b1;
                st_start_chan = CW'(c);
                st_start_len  = eff_len[c];
            end
            if (ist_set[c]) d.len[c] = '0;
        end

        d.ist = q.ist;
        if (wr_en && addr == OFF_IST) d.ist = q.ist & ~wdata[NCH-1:0];
        d.ist = d.ist | ist_set;

        if (srst) begin
            d       = '0;
            d.tx_en = wdata[CTRL_EN_BIT];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        rdata = '0;
        if (addr == OFF_CTRL)  rdata[CTRL_EN_BIT] = q.tx_en;
        if (addr == OFF_CHSEL) rdata[CW-1:0] = q.chsel;
        if (addr == OFF_IEN)   rdata[NCH-1:0] = q.ien;
        if (addr == OFF_IST)   rdata[NCH-1:0] = q.ist;
        for (int c = 0; c < NCH; c++) begin
            if (addr == off_len(c)) rdata[LW-1:0] = q.len[c];
        end
    end

    assign tx_data = fifo_byte[st_chan];
    assign irq     = |(q.ist & q.ien);

    // Nothing launches while transmit is disabled
    p_start_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_valid && !q.tx_en |=> !tx_valid);
    // Stalled byte holds its value
    p_data_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && !tx_ready && !srst |=> tx_valid && $stable(tx_data));
    // Completion sets the channel's status bit and zeroes its length
    p_done_status_r8: assert property (@(posedge clk) disable iff (!rst_n)
        st_done && !srst |=> q.ist[$past(st_chan)]);
    p_done_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
        st_done && !srst |=> q.len[$past(st_chan)] == '0);
    // A frame in flight keeps its channel until its last byte is taken
    p_one_frame_r11: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && !(tx_ready && tx_eof) && !srst |=> tx_valid && $stable(st_chan));
endmodule

// File: tb/tb_txfe_top.sv
module tb_txfe_top;
    localparam int DEPTH = 16;
    localparam logic [7:0] A_CTRL = 8'h00, A_CHSEL = 8'h04, A_DATA = 8'h08,
                           A_LEN0 = 8'h0C, A_GO0 = 8'h14, A_IEN = 8'h1C, A_IST = 8'h20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [7:0]  tx_data;
    logic        tx_valid, tx_sof, tx_eof, irq;
    logic        tx_ready = 1'b0;

    int vectors = 0;
    int miscompares = 0;

    txfe_top #(.DEPTH_BYTES(DEPTH)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .tx_data(tx_data), .tx_valid(tx_valid), .tx_sof(tx_sof),
        .tx_eof(tx_eof), .tx_ready(tx_ready), .irq(irq)
    );

    always #5 clk = ~clk;

    task automatic check(input string tag, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] v);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = v;
        @(posedge clk);
        #1 wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output int v);
        @(negedge clk);
        addr = a;
        #1 v = int'(rdata);
    endtask

    function automatic logic [7:0] pb(input int ch, input int w, input int b);
        return 8'(ch * 128 + w * 4 + b + 1);
    endfunction

    function automatic logic [31:0] pword(input int ch, input int w);
        return {pb(ch, w, 3), pb(ch, w, 2), pb(ch, w, 1), pb(ch, w, 0)};
    endfunction

    function automatic int imin(input int a, input int b);
        return (a < b) ? a : b;
    endfunction

    // Receive one frame; stall_mode 1 inserts ready gaps
    task automatic collect(input int ch, input int n, input int stall_mode, input string tag);
        int got = 0;
        int bad_data = 0;
        int bad_mark = 0;
        int bad_hold = 0;
        logic [7:0] prevd = '0;
        logic prevstall = 1'b0;
        int limit = (n == 0) ? 6 : n * 4 + 10;
        for (int cyc = 0; cyc < limit; cyc++) begin
            logic rdy;
            @(negedge clk);
            if (prevstall && tx_valid && tx_data !== prevd) bad_hold++;
            rdy = (stall_mode == 0) ? 1'b1 : ((cyc % 3) != 1);
            tx_ready = rdy;
            if (tx_valid) begin
                if (rdy) begin
                    if (tx_data !== pb(ch, got / 4, got % 4)) bad_data++;
                    if (tx_sof !== (got == 0)) bad_mark++;
                    if (tx_eof !== (got == n - 1)) bad_mark++;
                    got++;
                end
                prevstall = !rdy;
                prevd = tx_data;
            end else begin
                prevstall = 1'b0;
            end
            if (n > 0 && got == n) break;
        end
        @(negedge clk);
        tx_ready = 1'b0;
        check({tag, " R6 byte count"}, got, n);
        check({tag, " R6 no extra byte"}, int'(tx_valid), 0);
        check({tag, " R1 byte order"}, bad_data, 0);
        check({tag, " R7 sof/eof"}, bad_mark, 0);
        check({tag, " R7 stall hold"}, bad_hold, 0);
    endtask

    initial begin
        int v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R10: reset state
        rd(A_CTRL, v);  check("R10 reset ctrl", v, 0);
        rd(A_CHSEL, v); check("R10 reset chsel", v, 0);
        rd(A_LEN0, v);  check("R10 reset len0", v, 0);
        rd(A_IST, v);   check("R10 reset ist", v, 0);
        check("R10 reset irq", int'(irq), 0);
        check("R10 reset valid", int'(tx_valid), 0);

        // R3: channel-select sweep
        for (int s = 0; s < 8; s++) begin
            wr(A_CHSEL, 32'(s));
            rd(A_CHSEL, v);
            check("R3 chsel", v, (s < 2) ? s : 0);
        end
        wr(A_CHSEL, 32'hFFFF_FFFF);
        rd(A_CHSEL, v); check("R3 chsel max", v, 0);

        // R10: control storage
        wr(A_CTRL, 32'h3); rd(A_CTRL, v); check("R10 ctrl rst bit not stored", v, 2);
        wr(A_CTRL, 32'h0); rd(A_CTRL, v); check("R10 ctrl clear", v, 0);

        // R5: start gated by enable and by bit 0
        wr(A_CHSEL, 0); wr(A_DATA, pword(0, 0)); wr(A_LEN0, 4);
        wr(A_GO0, 1);
        collect(0, 0, 0, "R5 disabled");
        rd(A_IST, v); check("R5 disabled no status", v, 0);
        wr(A_CTRL, 2);
        wr(A_GO0, 2);
        collect(0, 0, 0, "R5 bit0 clear");
        wr(A_GO0, 1);
        collect(0, 4, 1, "R5 enabled");

        // Exhaustive sweep: channel x words pushed x programmed length
        for (int ch = 0; ch < 2; ch++) begin
            for (int nw = 0; nw <= 5; nw++) begin
                for (int len = 0; len <= 19; len++) begin
                    int plen = (len == 19) ? 1000 : len;
                    int cl = imin(plen, DEPTH);
                    int n = imin(cl, imin(nw * 4, DEPTH));
                    wr(A_CTRL, 3);
                    wr(A_IEN, 3);
                    wr(A_CHSEL, 32'(ch));
                    for (int w = 0; w < nw; w++) wr(A_DATA, pword(ch, w));
                    wr(A_LEN0 + 8'(4 * ch), 32'(plen));
                    rd(A_LEN0 + 8'(4 * ch), v); check("R4 length clamp", v, cl);
                    wr(A_GO0 + 8'(4 * ch), 1);
                    collect(ch, n, (len % 2), "R1 sweep");
                    rd(A_IST, v); check("R8 status bit", v, (n > 0) ? (1 << ch) : 0);
                    check("R9 irq level", int'(irq), (n > 0) ? 1 : 0);
                    rd(A_LEN0 + 8'(4 * ch), v); check("R8 length cleared", v, (n > 0) ? 0 : cl);
                    rd(A_LEN0 + 8'(4 * (1 - ch)), v); check("R1 other channel length", v, 0);
                    if (n > 0) begin
                        wr(A_LEN0 + 8'(4 * ch), 8);
                        wr(A_GO0 + 8'(4 * ch), 1);
                        collect(ch, 0, 0, "R8 queue emptied");
                    end
                end
            end
        end

        // R11: go on another channel while streaming is ignored
        wr(A_CTRL, 3); wr(A_IEN, 3);
        wr(A_CHSEL, 0); wr(A_DATA, pword(0, 0)); wr(A_DATA, pword(0, 1));
        wr(A_CHSEL, 1); wr(A_DATA, pword(1, 0));
        wr(A_LEN0, 8); wr(A_LEN0 + 8'd4, 4);
        wr(A_GO0, 1);
        wr(A_GO0 + 8'd4, 1);
        wr(A_GO0, 1);
        collect(0, 8, 1, "R11 first frame");
        collect(1, 0, 0, "R11 no second frame");
        rd(A_IST, v); check("R11 only ch0 status", v, 1);
        rd(A_LEN0 + 8'd4, v); check("R11 ch1 length kept", v, 4);

        // R9: enable masking and write-one-to-clear
        wr(A_IEN, 2); check("R9 masked irq", int'(irq), 0);
        wr(A_IEN, 1); check("R9 enabled irq", int'(irq), 1);
        wr(A_IST, 1);
        rd(A_IST, v); check("R9 w1c", v, 0);
        check("R9 irq after clear", int'(irq), 0);

        // R9: completion wins over a same-cycle clear
        wr(A_GO0 + 8'd4, 1);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk); tx_ready = 1'b1;
        end
        @(negedge clk);
        check("R7 eof on last", int'(tx_eof), 1);
        tx_ready = 1'b1; wr_en = 1'b1; addr = A_IST; wdata = 32'h3;
        @(posedge clk);
        #1 wr_en = 1'b0; tx_ready = 1'b0;
        rd(A_IST, v); check("R9 set beats clear", v, 2);

        // R10: soft reset mid-frame
        wr(A_CHSEL, 0); wr(A_DATA, pword(0, 0)); wr(A_DATA, pword(0, 1));
        wr(A_LEN0, 8); wr(A_GO0, 1);
        @(negedge clk); check("R10 frame running", int'(tx_valid), 1);
        wr(A_CTRL, 3);
        @(negedge clk); check("R10 frame cut", int'(tx_valid), 0);
        rd(A_IST, v); check("R10 status cleared", v, 0);
        rd(A_CTRL, v); check("R10 enable kept from write", v, 2);
        wr(A_LEN0, 8); wr(A_GO0, 1);
        collect(0, 0, 0, "R10 queue flushed");

        // R2: overflow drop at full depth
        wr(A_CTRL, 3); wr(A_CHSEL, 1);
        for (int w = 0; w < 6; w++) wr(A_DATA, pword(1, w));
        wr(A_LEN0 + 8'd4, 100);
        wr(A_GO0 + 8'd4, 1);
        collect(1, DEPTH, 1, "R2 full queue");

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule